// File: doc/BRIEF.md
# Prioritised Interrupt Status and Level Controller

This block gathers thirteen level-sensitive peripheral interrupt lines into one 32-bit status word. It gates that word with a separate 32-bit enable mask and tells the processor which of three priority levels is being requested, along with the matching autovector number. Each source owns one fixed status bit, and the bit positions are scattered across the word. A rising edge on a source sets its bit and a falling edge clears it.

Software can read the status word and can also overwrite it completely. It can read and write the mask. Both sit on a simple register bus with a write strobe, a 16-bit offset and a combinational read path.

A separate strobe carries the CPU-DMA mode bit from writes to the disk-controller control byte. That bit forces the disk-DMA status bit high or low. The requested level and vector are registered, so they follow the status and mask by one clock.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word, the mask, `cpu_ipl` and `cpu_vector` are all zero.
- R2: A rising edge on `src_in[i]` sets a fixed status bit. The map from source index to status bit is: 0→7 (floppy), 1→3 (keyboard), 2→2 (power), 3→9 (net receive), 4→10 (net transmit), 5→12 (disk), 6→5 (timer), 7→17 (serial), 8→28 (net-transmit DMA), 9→27 (net-receive DMA), 10→26 (disk DMA), 11→23 (audio) and 12→21 (serial DMA).
- R3: A falling edge on `src_in[i]` clears that source's status bit.
- R4: A bus write to offset 0x7000 replaces all 32 status bits with `bus_wdata`. A read at 0x7000 returns the status word.
- R5: Offset 0x7800 reads and writes the mask. Reads at any other offset return zero, and writes there change neither register.
- R6: A pulse on `scsi_ctl_wr` copies `scsi_cpudma` (bit 4 of the control byte) into status bit 26 and leaves the other status bits alone.
- R7: When several updates hit the same cycle, source edges take precedence over the disk-control update, and the disk-control update takes precedence over a bus write to the status word.
- R8: `cpu_ipl` is 6 if any enabled pending bit is in {21,23,26,27,28}. Otherwise it is 5 if bit 17 is enabled and pending. Otherwise it is 3 if any enabled pending bit is in {2,3,5,7,9,10,12}. Otherwise it is 0. A bit is enabled when its mask bit is 1.
- R9: `cpu_vector` is 24 plus `cpu_ipl` (27, 29 or 30) while a level is requested, and 0 when no level is requested.
- R10: `cpu_ipl` and `cpu_vector` change exactly one clock after the status or mask change that causes them.
- R11: Status bits outside the three groups never raise a request, even when pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 13 | Level-sensitive interrupt sources, indexed as in R2 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| scsi_ctl_wr | input | 1 | Strobe for a write of the disk-controller control byte |
| scsi_cpudma | input | 1 | CPU-DMA mode bit of that control byte |
| cpu_ipl | output | 3 | Requested processor priority level (0, 3, 5 or 6) |
| cpu_vector | output | 8 | Autovector number for the requested level |

## Verification
A source edge or register write applied before a rising clock edge shows up in the status and mask read-back right after that edge. The level and vector show up after the following edge. The bench drives every input on a falling edge. It reads the registers at the next falling edge and checks the level and vector one falling edge later. One dedicated sequence also checks that the level still holds its old value at the intermediate falling edge.

// File: rtl/irqc_pkg.sv
// Package: irqc_pkg
// Shared constants for the interrupt level controller: the fixed map from
// source index to status bit, the priority level of each source, and the
// helper that builds the per-level group masks from that map.
package irqc_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned NUM_SRC    = 13;
    localparam int unsigned IPL_W      = 3;
    localparam int unsigned VEC_W      = 8;

    localparam int unsigned LVL_LOW    = 3;
    localparam int unsigned LVL_MID    = 5;
    localparam int unsigned LVL_HIGH   = 6;

    // Status bit owned by each source index.
    localparam int unsigned SRC_BIT [NUM_SRC] =
        '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};

    // Priority level requested by each source index.
    localparam int unsigned SRC_LVL [NUM_SRC] =
        '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

    // Index of the disk-DMA source, whose bit is also driven by the control byte.
    localparam int unsigned SRC_DISK_DMA = 10;

    // Build the mask of all status bits that belong to one level.
    function automatic logic [DATA_W-1:0] group_bits(input int unsigned lvl);
        logic [DATA_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (SRC_LVL[i] == lvl) acc[SRC_BIT[i]] = 1'b1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/irqc_edge_detect.sv
// Module: irqc_edge_detect
// Samples each level-sensitive source once per clock and flags its rising
// and falling transitions for one cycle.
// Assumes the sources are already synchronous to clk. Reset clears the
// history, so a source that is high when reset lifts reads as a rising edge.
module irqc_edge_detect #(
    parameter int unsigned N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // Hold the previous sample of every source.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_in;
    end

    // Compare the current level with the stored one, per source.
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = lvl_in[i] & ~prev_q[i];
        assign fall[i] = ~lvl_in[i] & prev_q[i];
    end

endmodule

// File: rtl/irqc_status_regs.sv
// Module: irqc_status_regs
// Holds the status word and the enable mask. It decodes the register bus and
// applies source edges and the disk-control side effect to the status bits.
// Update order inside one cycle, lowest to highest precedence: bus write of
// the status word, disk-control bit, source edges.
module irqc_status_regs
    import irqc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STATUS_OFS   = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFS     = 16'h7800,
    parameter int unsigned       DISK_DMA_BIT = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] fall,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               scsi_ctl_wr,
    input  logic               scsi_cpudma,
    output logic [DATA_W-1:0]  status_q,
    output logic [DATA_W-1:0]  mask_q
);

    logic              wr_status;
    logic              wr_mask;
    logic [DATA_W-1:0] status_d;

    assign wr_status = bus_wr && (bus_addr == STATUS_OFS);
    assign wr_mask   = bus_wr && (bus_addr == MASK_OFS);

    // Next status word: software first, then the control byte, then edges.
    always_comb begin
        status_d = status_q;
        if (wr_status)   status_d = bus_wdata;
        if (scsi_ctl_wr) status_d[DISK_DMA_BIT] = scsi_cpudma;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rise[i]) status_d[SRC_BIT[i]] = 1'b1;
            if (fall[i]) status_d[SRC_BIT[i]] = 1'b0;
        end
    end

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Mask register, written only at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata;
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        if (bus_addr == STATUS_OFS)    bus_rdata = status_q;
        else if (bus_addr == MASK_OFS) bus_rdata = mask_q;
        else                           bus_rdata = '0;
    end

    // A rising source owns its bit on the next cycle; a falling one clears it.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> status_q[SRC_BIT[i]]);
        assert_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !status_q[SRC_BIT[i]]);
    end

    // A lone status write lands verbatim.
    assert_status_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !scsi_ctl_wr && (rise == '0) && (fall == '0))
        |=> (status_q == $past(bus_wdata)));

    // The mask moves only on a write to its offset.
    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(bus_wdata)));
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

    // The control byte sets or clears the disk-DMA bit unless that source's edge overrides it.
    assert_ctl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_ctl_wr && scsi_cpudma && !fall[SRC_DISK_DMA]) |=> status_q[DISK_DMA_BIT]);
    assert_ctl_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_ctl_wr && !scsi_cpudma && !rise[SRC_DISK_DMA]) |=> !status_q[DISK_DMA_BIT]);

endmodule

// File: rtl/irqc_level_encode.sv
// Module: irqc_level_encode
// Gates the status word with the mask, picks the highest requesting level
// group, and registers the level together with its autovector.
// Assumes the three levels are fixed and ordered high, mid, low. Bits outside
// every group are ignored.
module irqc_level_encode
    import irqc_pkg::*;
#(
    parameter int unsigned VEC_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic [IPL_W-1:0]  ipl_q,
    output logic [VEC_W-1:0]  vec_q
);

    localparam logic [DATA_W-1:0] GRP_HIGH = group_bits(LVL_HIGH);
    localparam logic [DATA_W-1:0] GRP_MID  = group_bits(LVL_MID);
    localparam logic [DATA_W-1:0] GRP_LOW  = group_bits(LVL_LOW);
    localparam logic [DATA_W-1:0] GRP_ANY  = GRP_HIGH | GRP_MID | GRP_LOW;

    logic [DATA_W-1:0] pend;
    logic [IPL_W-1:0]  ipl_d;

    assign pend = status_q & mask_q;

    // Fixed-priority choice of the highest enabled group.
    always_comb begin
        if (|(pend & GRP_HIGH))     ipl_d = IPL_W'(LVL_HIGH);
        else if (|(pend & GRP_MID)) ipl_d = IPL_W'(LVL_MID);
        else if (|(pend & GRP_LOW)) ipl_d = IPL_W'(LVL_LOW);
        else                        ipl_d = '0;
    end

    // Register the level and its autovector together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
            vec_q <= '0;
        end else begin
            ipl_q <= ipl_d;
            vec_q <= (ipl_d == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(ipl_d);
        end
    end

    // An enabled high-group bit wins one clock later.
    assert_high_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask_q & GRP_HIGH)) |=> (ipl_q == IPL_W'(LVL_HIGH)));

    // Mid group alone yields its own vector.
    assert_mid_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(status_q & mask_q & GRP_MID)) && !(|(status_q & mask_q & GRP_HIGH)))
        |=> (vec_q == VEC_W'(VEC_BASE + LVL_MID)));

    // Nothing enabled in any group means no request.
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & mask_q & GRP_ANY)) |=> ((ipl_q == '0) && (vec_q == '0)));

endmodule

// File: rtl/irq_level_ctrl.sv
// Module: irq_level_ctrl
// Top of the interrupt level controller: edge capture of the sources, the
// status and mask registers with their bus decode, and the level encoder.
// Assumes one synchronous clock domain and a single-cycle register bus.
module irq_level_ctrl
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               scsi_ctl_wr,
    input  logic               scsi_cpudma,
    output logic [IPL_W-1:0]   cpu_ipl,
    output logic [VEC_W-1:0]   cpu_vector
);

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;
    logic [DATA_W-1:0]  status_q;
    logic [DATA_W-1:0]  mask_q;

    irqc_edge_detect #(.N(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (src_in),
        .rise   (rise),
        .fall   (fall)
    );

    irqc_status_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .fall        (fall),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .scsi_ctl_wr (scsi_ctl_wr),
        .scsi_cpudma (scsi_cpudma),
        .status_q    (status_q),
        .mask_q      (mask_q)
    );

    irqc_level_encode u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .mask_q   (mask_q),
        .ipl_q    (cpu_ipl),
        .vec_q    (cpu_vector)
    );

    // Reset leaves no request at the processor.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> ((cpu_ipl == '0) && (cpu_vector == '0)));

    // The level only ever takes one of the four legal values.
    assert_legal_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ipl == 3'd0) || (cpu_ipl == 3'd3) || (cpu_ipl == 3'd5) || (cpu_ipl == 3'd6));

endmodule

// File: tb/test_irq_level_ctrl.sv
// Bench for irq_level_ctrl: sweeps every source, all group/mask combinations
// and the same-cycle precedence cases, against an arithmetic model.
module test_irq_level_ctrl;

    localparam logic [15:0] A_STAT = 16'h7000;
    localparam logic [15:0] A_MASK = 16'h7800;
    localparam logic [31:0] G_LOW  = 32'h0000_16AC;
    localparam logic [31:0] G_MID  = 32'h0002_0000;
    localparam logic [31:0] G_HIGH = 32'h1CA0_0000;
    localparam int SBIT [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] src_in;
    logic        bus_wr;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        scsi_ctl_wr;
    logic        scsi_cpudma;
    logic [2:0]  cpu_ipl;
    logic [7:0]  cpu_vector;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] e_stat;
    logic [31:0] e_mask;

    irq_level_ctrl i_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scsi_ctl_wr(scsi_ctl_wr), .scsi_cpudma(scsi_cpudma),
        .cpu_ipl(cpu_ipl), .cpu_vector(cpu_vector)
    );

    always #4 clk = ~clk;

    function automatic int exp_lvl(input logic [31:0] s, input logic [31:0] m);
        logic [31:0] p;
        p = s & m;
        if ((p & G_HIGH) != 0) return 6;
        if ((p & G_MID) != 0)  return 5;
        if ((p & G_LOW) != 0)  return 3;
        return 0;
    endfunction

    function automatic int exp_vec(input int l);
        return (l == 0) ? 0 : 24 + l;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Registers right now, level and vector one clock later.
    task automatic check_state(input string req);
        logic [31:0] d;
        int l;
        rd(A_STAT, d); chk({req, " status"}, d, e_stat);
        rd(A_MASK, d); chk({req, " mask"}, d, e_mask);
        @(negedge clk);
        l = exp_lvl(e_stat, e_mask);
        chk({req, " ipl"}, 32'(cpu_ipl), 32'(l));
        chk({req, " vector"}, 32'(cpu_vector), 32'(exp_vec(l)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; src_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        scsi_ctl_wr = 1'b0; scsi_cpudma = 1'b0;
        e_stat = '0; e_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state("R1");

        // R5: mask write and read-back
        wr(A_MASK, 32'hFFFF_FFFF); e_mask = 32'hFFFF_FFFF;
        check_state("R5");

        // R2/R3/R8/R9: every source up then down
        for (int i = 0; i < 13; i++) begin
            src_in[i] = 1'b1;
            @(negedge clk);
            e_stat[SBIT[i]] = 1'b1;
            check_state("R2");
            src_in[i] = 1'b0;
            @(negedge clk);
            e_stat[SBIT[i]] = 1'b0;
            check_state("R3");
        end

        // R10: level lags the status and the mask by exactly one clock
        src_in[7] = 1'b1;
        @(negedge clk);
        chk("R10 lag ipl", 32'(cpu_ipl), 32'd0);
        @(negedge clk);
        chk("R10 ipl", 32'(cpu_ipl), 32'd5);
        chk("R9 vector", 32'(cpu_vector), 32'd29);
        wr(A_MASK, ~32'h0002_0000);
        chk("R10 lag mask", 32'(cpu_ipl), 32'd5);
        @(negedge clk);
        chk("R10 masked", 32'(cpu_ipl), 32'd0);
        src_in[7] = 1'b0;
        @(negedge clk);
        wr(A_MASK, 32'hFFFF_FFFF);
        e_stat = '0;
        check_state("R3");

        // R4/R8/R9/R11: all group-pending by group-enable combinations
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 8; m++) begin
                logic [31:0] sv, mv;
                sv = 32'hE000_0013 | (s[0] ? 32'h0000_1000 : 0)
                                   | (s[1] ? 32'h0002_0000 : 0)
                                   | (s[2] ? 32'h0080_0000 : 0);
                mv = 32'hE000_0013 | (m[0] ? G_LOW : 0)
                                   | (m[1] ? G_MID : 0)
                                   | (m[2] ? G_HIGH : 0);
                wr(A_STAT, sv); e_stat = sv;
                wr(A_MASK, mv); e_mask = mv;
                check_state("R8");
            end
        end

        // R11: bits outside all groups, fully enabled
        wr(A_MASK, 32'hFFFF_FFFF); e_mask = 32'hFFFF_FFFF;
        wr(A_STAT, ~(G_LOW | G_MID | G_HIGH)); e_stat = ~(G_LOW | G_MID | G_HIGH);
        check_state("R11");

        // R5: unmapped offset reads zero and writes nothing
        wr(16'h7004, 32'h0000_0000);
        rd(16'h7004, d); chk("R5 unmapped read", d, 32'h0);
        wr(16'h7804, 32'h0000_0000);
        check_state("R5");

        // R6: control byte sets and clears bit 26 only
        wr(A_STAT, 32'h0000_0000); e_stat = 0;
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b1;
        @(negedge clk); scsi_ctl_wr = 1'b0;
        e_stat = 32'h0400_0000;
        check_state("R6");
        wr(A_STAT, 32'h0000_0084); e_stat = 32'h0000_0084;
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b1;
        @(negedge clk); scsi_ctl_wr = 1'b0;
        e_stat = 32'h0400_0084;
        check_state("R6");
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b0;
        @(negedge clk); scsi_ctl_wr = 1'b0;
        e_stat = 32'h0000_0084;
        check_state("R6");

        // R7: source edge beats a status write in the same cycle
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0;
        src_in[0] = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        e_stat = 32'h0000_0080;
        check_state("R7");
        src_in[0] = 1'b0;
        @(negedge clk); e_stat = 0;
        check_state("R3");

        // R7: disk-DMA rise beats a clearing control byte
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b0; src_in[10] = 1'b1;
        @(negedge clk); scsi_ctl_wr = 1'b0;
        e_stat = 32'h0400_0000;
        check_state("R7");

        // R7: disk-DMA fall beats a setting control byte
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b1; src_in[10] = 1'b0;
        @(negedge clk); scsi_ctl_wr = 1'b0;
        e_stat = 32'h0;
        check_state("R7");

        // R7: control byte beats a status write in the same cycle
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'hFFFF_FFFF;
        scsi_ctl_wr = 1'b1; scsi_cpudma = 1'b0;
        @(negedge clk); bus_wr = 1'b0; scsi_ctl_wr = 1'b0;
        e_stat = 32'hFBFF_FFFF;
        check_state("R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule